// File: doc/BRIEF.md
# FR-FCFS DRAM Command Scheduler

This block sits between the per-bank request queues of a memory controller and the command bus of one DRAM rank. Every memory clock it looks at the oldest queued request of each bank, works out which DRAM command that request needs next, and checks whether the command meets the timing rules. It then issues at most one command, chosen first-ready, then column-first, then oldest-first. Rows are left open after an access, so a later request to the same row needs only a read or write.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is a function of `req_bank`: it is low only while the queue of that bank is full, so a stalled request for one bank does not depend on the state of other banks. The sender must hold the request stable while `req_ready` is low. The command outputs are an issue strobe with no back-pressure, because the command bus cannot stall. Each request carries an arrival stamp from a wrapping counter, and age is judged on that stamp. A plain control pair, `prio_en` and `prio_bank`, can favour one bank over the age order.

Top module: `frfcfs_cmd_sched`

## Requirements
- R1: A request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` is high exactly when the queue of `req_bank` (QDEPTH entries) is not full. An accepted request can be scheduled from the next cycle on.
- R2: `cmd_type` is encoded PRE=0, ACT=1, RD=2, WR=3, and `cmd_row` carries the row of the request. A request to a bank with another row open gets PRE, then ACT, then its column command. A request to a closed bank gets ACT, then the column command. A request to the open row gets the column command only.
- R3: A row stays open after a column command, so a following request to the same row issues with no ACT.
- R4: Per bank, a column command waits T_RCD (7) cycles after ACT. PRE waits T_RTP (4) cycles after any column command. ACT waits T_RP (7) cycles after PRE and T_RC (27) cycles after the previous ACT to that bank.
- R5: Across banks, column commands are at least T_CCD (4) cycles apart and ACT commands at least T_RRD (4) cycles apart.
- R6: No window of T_FAW (20) consecutive cycles holds more than four ACT commands.
- R7: Commands to one bank may issue while the timers of another bank are still running, so activations and accesses of different banks overlap.
- R8: At most one command issues per cycle, and `cmd_valid` is low when nothing is issued.
- R9: Only commands that meet every timing rule compete. Among them, a column command beats a PRE or ACT regardless of age.
- R10: Within the same class, the older stamp wins. Stamp a is older than stamp b when (a−b) mod 2^STAMP_W is at least 2^(STAMP_W−1), so the stamp may wrap. On equal stamps the lower bank index wins.
- R11: With `prio_en` high, a ready command of bank `prio_bank` beats ready commands of the same class from other banks, even older ones. It does not beat a column command when its own command is PRE or ACT.
- R12: `done_valid` pulses in the cycle a column command issues, with `done_stamp` set to that request's stamp. The request then leaves its queue, which frees one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue of `req_bank` has room |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_stamp | input | STAMP_W | Arrival stamp |
| prio_en | input | 1 | Enable the favoured bank |
| prio_bank | input | BANK_W | Favoured bank |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_type | output | 2 | PRE=0, ACT=1, RD=2, WR=3 |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the request served |
| done_valid | output | 1 | Column command issued, request retired |
| done_stamp | output | STAMP_W | Stamp of the retired request |

## Verification
The bench builds the block with eight banks, two-entry queues, 8-bit rows and 8-bit stamps, and keeps the default timing values. With eight banks, a fifth activation can fall inside the four-activate window. Two-entry queues let a third request to one bank run into back-pressure and then see it released when a read retires. The 8-bit stamps let a short test span the wrap point, so oldest-first is tested across a wrapped counter.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;
endpackage

// File: rtl/fr_bank_queue.sv
module fr_bank_queue #(
  parameter int ROW_W   = 14,
  parameter int STAMP_W = 8,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ROW_W-1:0]   in_row,
  input  logic               in_wr,
  input  logic [STAMP_W-1:0] in_stamp,
  input  logic               pop,
  output logic               full,
  output logic               hd_valid,
  output logic [ROW_W-1:0]   hd_row,
  output logic               hd_wr,
  output logic [STAMP_W-1:0] hd_stamp
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ROW_W-1:0]   row_m   [DEPTH];
  logic               wr_m    [DEPTH];
  logic [STAMP_W-1:0] stamp_m [DEPTH];
  logic [PW-1:0]      wp, rp;
  logic [CW-1:0]      cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      row_m[wp]   <= in_row;
      wr_m[wp]    <= in_wr;
      stamp_m[wp] <= in_stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full     = (cnt == CW'(DEPTH));
  assign hd_valid = (cnt != '0);
  assign hd_row   = row_m[rp];
  assign hd_wr    = wr_m[rp];
  assign hd_stamp = stamp_m[rp];

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/fr_bank_ctl.sv
module fr_bank_ctl import frfcfs_pkg::*; #(
  parameter int ROW_W = 14,
  parameter int T_RP  = 7,
  parameter int T_RCD = 7,
  parameter int T_RTP = 4,
  parameter int T_RC  = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_valid,
  input  logic [ROW_W-1:0] hd_row,
  input  logic             hd_wr,
  input  logic             iss,
  input  logic             bus_col_ok,
  input  logic             bus_act_ok,
  output logic             cand_rdy,
  output logic             cand_col,
  output cmd_e             cand_type
);
  localparam int TMAX = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int TW   = $clog2(TMAX + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [TW-1:0]    t_col, t_act, t_pre;
  logic             hit;

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [TW-1:0] maxv(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign hit = open_q && (row_q == hd_row);

  always_comb begin
    if (hit)         cand_type = hd_wr ? CMD_WR : CMD_RD;
    else if (open_q) cand_type = CMD_PRE;
    else             cand_type = CMD_ACT;
    cand_col = hit;
    case (cand_type)
      CMD_RD, CMD_WR: cand_rdy = hd_valid && (t_col == '0) && bus_col_ok;
      CMD_PRE:        cand_rdy = hd_valid && (t_pre == '0);
      default:        cand_rdy = hd_valid && (t_act == '0) && bus_act_ok;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      t_col  <= '0;
      t_act  <= '0;
      t_pre  <= '0;
    end else begin
      t_col <= dec(t_col);
      t_act <= dec(t_act);
      t_pre <= dec(t_pre);
      if (iss) begin
        case (cand_type)
          CMD_ACT: begin
            open_q <= 1'b1;
            row_q  <= hd_row;
            t_col  <= TW'(T_RCD - 1);
            t_act  <= TW'(T_RC - 1);
          end
          CMD_PRE: begin
            open_q <= 1'b0;
            t_act  <= maxv(dec(t_act), TW'(T_RP - 1));
          end
          default: t_pre <= TW'(T_RTP - 1);
        endcase
      end
    end
  end

  p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cand_col) |=> open_q);
  p_act_on_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cand_type == CMD_ACT) |-> !open_q);
  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cand_type == CMD_ACT) |=> !(iss && cand_col));
  p_rtp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cand_col) |=> !(iss && cand_type == CMD_PRE));
endmodule

// File: rtl/fr_bus_timers.sv
module fr_bus_timers #(
  parameter int T_CCD    = 4,
  parameter int T_RRD    = 4,
  parameter int T_FAW    = 20,
  parameter int FAW_ACTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_iss,
  input  logic act_iss,
  output logic col_ok,
  output logic act_ok
);
  localparam int TW = $clog2(((T_CCD > T_RRD) ? T_CCD : T_RRD) + 1);
  localparam int HW = T_FAW - 1;
  localparam int NW = $clog2(HW + 1);

  logic [TW-1:0] t_ccd, t_rrd;
  logic [HW-1:0] hist;
  logic [NW-1:0] n_act;

  always_comb begin
    n_act = '0;
    for (int i = 0; i < HW; i++) n_act = n_act + NW'(hist[i]);
  end

  assign col_ok = (t_ccd == '0);
  assign act_ok = (t_rrd == '0) && (n_act < NW'(FAW_ACTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_ccd <= '0;
      t_rrd <= '0;
      hist  <= '0;
    end else begin
      t_ccd <= col_iss ? TW'(T_CCD - 1) : ((t_ccd == '0) ? '0 : t_ccd - 1'b1);
      t_rrd <= act_iss ? TW'(T_RRD - 1) : ((t_rrd == '0) ? '0 : t_rrd - 1'b1);
      hist  <= {hist[HW-2:0], act_iss};
    end
  end

  p_ccd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_iss |=> !col_iss);
  p_rrd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_iss |=> !act_iss);
endmodule

// File: rtl/fr_pick.sv
module fr_pick #(
  parameter int NB      = 8,
  parameter int STAMP_W = 8,
  parameter int BW      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NB-1:0]              rdy,
  input  logic [NB-1:0]              col,
  input  logic [NB-1:0][STAMP_W-1:0] stamp,
  input  logic                       prio_en,
  input  logic [BW-1:0]              prio_bank,
  output logic [NB-1:0]              gnt,
  output logic                       any,
  output logic [BW-1:0]              sel
);
  function automatic logic older(input logic [STAMP_W-1:0] a, input logic [STAMP_W-1:0] b);
    logic [STAMP_W-1:0] d;
    d = a - b;
    return d[STAMP_W-1];
  endfunction

  function automatic logic beats(input logic ca, input logic pa, input logic [STAMP_W-1:0] sa,
                                 input logic cb, input logic pb, input logic [STAMP_W-1:0] sb);
    if (ca != cb) return ca;
    if (pa != pb) return pa;
    return older(sa, sb);
  endfunction

  always_comb begin
    logic cur_p, new_p;
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < NB; i++) begin
      new_p = prio_en && (prio_bank == BW'(i));
      cur_p = prio_en && (prio_bank == sel);
      if (rdy[i] && (!any || beats(col[i], new_p, stamp[i], col[sel], cur_p, stamp[sel]))) begin
        sel = BW'(i);
        any = 1'b1;
      end
    end
    gnt = '0;
    if (any) gnt[sel] = 1'b1;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_column_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rdy & col)) |-> (any && col[sel]));
endmodule

// File: rtl/frfcfs_cmd_sched.sv
module frfcfs_cmd_sched import frfcfs_pkg::*; #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int STAMP_W   = 8,
  parameter int QDEPTH    = 4,
  parameter int T_RP      = 7,
  parameter int T_RCD     = 7,
  parameter int T_RTP     = 4,
  parameter int T_RC      = 27,
  parameter int T_CCD     = 4,
  parameter int T_RRD     = 4,
  parameter int T_FAW     = 20,
  parameter int FAW_ACTS  = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0]   req_row,
  input  logic               req_write,
  input  logic [STAMP_W-1:0] req_stamp,
  input  logic               prio_en,
  input  logic [BANK_W-1:0]  prio_bank,
  output logic               cmd_valid,
  output logic [1:0]         cmd_type,
  output logic [BANK_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0]   cmd_row,
  output logic               done_valid,
  output logic [STAMP_W-1:0] done_stamp
);
  logic [NUM_BANKS-1:0]              full, hd_valid, hd_wr, push, pop;
  logic [NUM_BANKS-1:0]              cand_rdy, cand_col, gnt;
  logic [ROW_W-1:0]                  hd_row [NUM_BANKS];
  logic [NUM_BANKS-1:0][STAMP_W-1:0] hd_stamp;
  cmd_e                              cand_type [NUM_BANKS];
  logic                              bus_col_ok, bus_act_ok, any;
  logic [BANK_W-1:0]                 sel;

  assign req_ready = (int'(req_bank) < NUM_BANKS) && !full[req_bank];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign push[g] = req_valid && req_ready && (req_bank == BANK_W'(g));
    assign pop[g]  = gnt[g] && cand_col[g];

    fr_bank_queue #(.ROW_W(ROW_W), .STAMP_W(STAMP_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push[g]), .in_row(req_row), .in_wr(req_write),
      .in_stamp(req_stamp), .pop(pop[g]), .full(full[g]), .hd_valid(hd_valid[g]),
      .hd_row(hd_row[g]), .hd_wr(hd_wr[g]), .hd_stamp(hd_stamp[g]));

    fr_bank_ctl #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RTP(T_RTP), .T_RC(T_RC)) u_ctl (
      .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid[g]), .hd_row(hd_row[g]), .hd_wr(hd_wr[g]),
      .iss(gnt[g]), .bus_col_ok(bus_col_ok), .bus_act_ok(bus_act_ok),
      .cand_rdy(cand_rdy[g]), .cand_col(cand_col[g]), .cand_type(cand_type[g]));
  end

  fr_pick #(.NB(NUM_BANKS), .STAMP_W(STAMP_W), .BW(BANK_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .rdy(cand_rdy), .col(cand_col), .stamp(hd_stamp),
    .prio_en(prio_en), .prio_bank(prio_bank), .gnt(gnt), .any(any), .sel(sel));

  fr_bus_timers #(.T_CCD(T_CCD), .T_RRD(T_RRD), .T_FAW(T_FAW), .FAW_ACTS(FAW_ACTS)) u_bus (
    .clk(clk), .rst_n(rst_n), .col_iss(done_valid),
    .act_iss(cmd_valid && (cmd_type == 2'(CMD_ACT))),
    .col_ok(bus_col_ok), .act_ok(bus_act_ok));

  assign cmd_valid  = any;
  assign cmd_type   = 2'(cand_type[sel]);
  assign cmd_bank   = sel;
  assign cmd_row    = hd_row[sel];
  assign done_valid = any && cand_col[sel];
  assign done_stamp = hd_stamp[sel];

  p_done_with_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cmd_valid && cmd_type[1]));
endmodule

// File: tb/frfcfs_cmd_sched_tb.sv
module frfcfs_cmd_sched_tb;
  localparam int NB = 8, RW = 8, SW = 8, QD = 2, BW = 3;
  localparam int NT = 36, LOGN = 128, NSC = 6;

  // {scenario, rel cycle, type, bank, row, stamp}
  localparam logic [35:0] TBL [NT] = '{
    36'h0_01_1_0_05_01, 36'h0_08_2_0_05_01, 36'h0_0C_3_0_05_02,
    36'h0_10_0_0_09_03, 36'h0_1C_1_0_09_03, 36'h0_23_2_0_09_03,
    36'h1_01_1_0_10_01, 36'h1_05_1_1_11_02, 36'h1_08_2_0_10_01,
    36'h1_09_1_2_12_03, 36'h1_0C_2_1_11_02, 36'h1_0D_1_3_13_04,
    36'h1_10_2_2_12_03, 36'h1_14_2_3_13_04, 36'h1_15_1_4_14_05,
    36'h1_1C_2_4_14_05,
    36'h2_01_1_0_01_10, 36'h2_08_2_0_01_10, 36'h2_09_1_1_02_05,
    36'h2_10_2_1_02_05,
    36'h3_01_1_0_00_F0, 36'h3_05_1_3_04_FA, 36'h3_08_2_0_00_F0,
    36'h3_09_1_2_03_03, 36'h3_0C_2_3_04_FA, 36'h3_10_2_2_03_03,
    36'h4_01_1_0_00_F0, 36'h4_05_1_2_03_03, 36'h4_08_2_0_00_F0,
    36'h4_09_1_3_04_FA, 36'h4_0C_2_2_03_03, 36'h4_10_2_3_04_FA,
    36'h5_01_1_5_07_01, 36'h5_08_2_5_07_01, 36'h5_0C_2_5_07_02,
    36'h5_10_2_5_07_03
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, prio_en = 1'b0;
  logic [BW-1:0] req_bank = '0, prio_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [SW-1:0] req_stamp = '0;
  logic req_ready, cmd_valid, done_valid;
  logic [1:0] cmd_type;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [SW-1:0] done_stamp;

  always #4 clk = ~clk;

  frfcfs_cmd_sched #(.NUM_BANKS(NB), .ROW_W(RW), .STAMP_W(SW), .QDEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_write(req_write), .req_stamp(req_stamp),
    .prio_en(prio_en), .prio_bank(prio_bank), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .done_valid(done_valid), .done_stamp(done_stamp));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int cur_scen = 0, nlog = 0, checks = 0, fails = 0;
  int base [NSC];
  int lg_cyc [LOGN], lg_scen [LOGN], lg_type [LOGN], lg_bank [LOGN], lg_row [LOGN];
  int lg_done [LOGN], lg_dst [LOGN];

  always @(negedge clk) begin
    if (rst_n && cmd_valid && nlog < LOGN) begin
      lg_cyc[nlog]  = cyc;       lg_scen[nlog] = cur_scen;
      lg_type[nlog] = cmd_type;  lg_bank[nlog] = cmd_bank;
      lg_row[nlog]  = cmd_row;   lg_done[nlog] = done_valid;
      lg_dst[nlog]  = done_stamp;
      nlog = nlog + 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2 R3 R4 sequence";
      1: return "R5 R6 R7 overlap/FAW";
      2: return "R9 column first";
      3: return "R10 oldest wrap";
      4: return "R11 favoured bank";
      default: return "R1 R12 queue retire";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; prio_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int b, input int r, input bit w, input int s);
    req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(r); req_write = w; req_stamp = SW'(s);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rel(input int s, input int rel);
    while (cyc < base[s] + rel) @(negedge clk);
  endtask

  initial begin
    int p [NSC];
    do_reset();
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R8 reset idle", cmd_valid, 0);
    chk(done_valid == 1'b0, "R12 reset done", done_valid, 0);

    // scen 0: miss, hit, conflict on one bank
    cur_scen = 0; base[0] = cyc;
    push(0, 5, 0, 1); push(0, 5, 1, 2); push(0, 9, 0, 3);
    wait_rel(0, 60);
    // scen 1: five banks, tRRD and four-activate window
    do_reset(); cur_scen = 1; base[1] = cyc;
    for (int b = 0; b < 5; b++) push(b, 16 + b, 0, b + 1);
    wait_rel(1, 50);
    // scen 2: older ACT against younger ready RD
    do_reset(); cur_scen = 2; base[2] = cyc;
    push(0, 1, 0, 16);
    wait_rel(2, 7);
    push(1, 2, 0, 5);
    wait_rel(2, 40);
    // scen 3: age across the stamp wrap
    do_reset(); cur_scen = 3; base[3] = cyc;
    push(0, 0, 0, 240); push(2, 3, 0, 3); push(3, 4, 0, 250);
    wait_rel(3, 40);
    // scen 4: same with bank 2 favoured
    do_reset(); cur_scen = 4; prio_en = 1'b1; prio_bank = 3'd2; base[4] = cyc;
    push(0, 0, 0, 240); push(2, 3, 0, 3); push(3, 4, 0, 250);
    wait_rel(4, 40);
    prio_en = 1'b0;
    // scen 5: queue full, then freed by a retiring read
    do_reset(); cur_scen = 5; base[5] = cyc;
    push(5, 7, 0, 1); push(5, 7, 0, 2);
    wait_rel(5, 2);
    req_valid = 1'b1; req_bank = 3'd5; req_row = 8'd7; req_write = 1'b0; req_stamp = 8'd3;
    #1 chk(req_ready == 1'b0, "R1 full queue", req_ready, 0);
    wait_rel(5, 8);
    #1 chk(req_ready == 1'b0, "R1 full before retire", req_ready, 0);
    wait_rel(5, 9);
    #1 chk(req_ready == 1'b1, "R12 entry freed", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    wait_rel(5, 40);

    for (int s = 0; s < NSC; s++) p[s] = 0;
    for (int t = 0; t < NT; t++) begin
      int s, k;
      s = int'(TBL[t][35:32]);
      while (p[s] < nlog && lg_scen[p[s]] != s) p[s]++;
      k = p[s];
      if (k >= nlog) begin
        chk(1'b0, tag_of(s), -1, int'(TBL[t][31:24]));
      end else begin
        chk(lg_cyc[k] - base[s] == int'(TBL[t][31:24]), tag_of(s), lg_cyc[k] - base[s], int'(TBL[t][31:24]));
        chk(lg_type[k] == int'(TBL[t][23:20]), tag_of(s), lg_type[k], int'(TBL[t][23:20]));
        chk(lg_bank[k] == int'(TBL[t][19:16]), tag_of(s), lg_bank[k], int'(TBL[t][19:16]));
        chk(lg_row[k] == int'(TBL[t][15:8]), tag_of(s), lg_row[k], int'(TBL[t][15:8]));
        if (TBL[t][21]) begin
          chk(lg_done[k] == 1, "R12 done pulse", lg_done[k], 1);
          chk(lg_dst[k] == int'(TBL[t][7:0]), "R12 done stamp", lg_dst[k], int'(TBL[t][7:0]));
        end else begin
          chk(lg_done[k] == 0, "R12 no done on row cmd", lg_done[k], 0);
        end
        p[s]++;
      end
    end
    for (int s = 0; s < NSC; s++) begin
      int got, want;
      got = 0; want = 0;
      for (int k = 0; k < nlog; k++) if (lg_scen[k] == s) got++;
      for (int t = 0; t < NT; t++) if (int'(TBL[t][35:32]) == s) want++;
      chk(got == want, "R8 command count", got, want);
    end
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule